// File: doc/BRIEF.md
# Instruction Fetch and Program Counter Sequencer

This block is the front end of a small processor whose instructions are all 16 bits wide. It owns the program counter, drives the instruction memory address, and places each fetched instruction into an execute-stage register. Together these form a two-stage pipeline. While one instruction sits in the execute stage, the next is being fetched. With no stalls, one instruction leaves the execute stage on every clock.

The next program counter comes from one of three sources. The first is sequential advance by 2 bytes. The second is a branch target, which is loaded only when the requested condition code holds against the supplied status flags. The third is a handler address, which is read through a separate data read port from a vector table of 4-byte entries. Out of reset the block reads entry 0 at the fixed table base 0xC00000 and starts execution at the address it returns. Software may later move the table to any 1 KB-aligned base by writing the base register. A memory wait input holds the execute stage, and fetch does not advance past it.

The execute-stage output is a valid-only stream. `mem_wait` acts as its inverted ready. While `mem_wait` is high, `ex_valid`, `ex_pc` and `ex_instr` are held and the program counter does not move. Branch and exception requests are not acted on until the wait ends. The vector read port is a request/valid pair: `vec_rd_req` stays high with a stable address until `vec_rd_valid` is returned.

Top module: `fetch_pc_seq`

## Requirements
- R1: After reset the block asserts `vec_rd_req` with `vec_rd_addr` = 0xC00000 (vector entry 0). No instruction is issued until that read returns. Fetching then starts at the returned address.
- R2: Reset sets the table base register to 0xC00000, and `base_rd_data` returns it.
- R3: Without stalls or redirects, `ex_pc` advances by 2 each clock. `ex_instr` is the instruction memory word fetched at `ex_pc`.
- R4: A branch request whose condition holds loads `br_target` into the program counter. The condition codes in `br_cond` are:
  - 0 always, 15 never;
  - 1 Z, 2 !Z;
  - 3 C, 4 !C;
  - 5 N, 6 !N;
  - 7 V, 8 !V;
  - 9 !Z&&(N==V), 10 N==V, 11 N!=V, 12 Z||(N!=V);
  - 13 !C&&!Z, 14 C||Z.
  
  The flag bits in `br_flags` are [3]=N, [2]=Z, [1]=V, [0]=C.
- R5: A branch request whose condition fails has no effect: the sequence continues by +2 with no bubble.
- R6: A write to the base register stores the written value with bits [9:0] forced to zero. Reads return that value.
- R7: An exception request reads the vector entry at base + 4 × `exc_vec` and loads the returned word into the program counter.
- R8: While `mem_wait` is high, `ex_valid`, `ex_pc`, `ex_instr` and `imem_addr` hold, and pending branch or exception requests are not acted on.
- R9: An accepted taken branch or exception turns the instruction in fetch into a bubble: `ex_valid` is 0 on the next cycle.
- R10: While a vector read is in progress, branch and exception requests are ignored. When an exception and a taken branch arrive together, the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_req | output | 1 | Instruction fetch active |
| imem_addr | output | 24 | Instruction fetch address (the program counter) |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, same cycle |
| vec_rd_req | output | 1 | Vector table read request |
| vec_rd_addr | output | 24 | Vector entry address |
| vec_rd_valid | input | 1 | Vector read data valid |
| vec_rd_data | input | 24 | Handler address returned from the table |
| br_req | input | 1 | Branch request from the execute stage |
| br_cond | input | 4 | Branch condition code |
| br_flags | input | 4 | Status flags N, Z, V, C |
| br_target | input | 24 | Branch target address |
| exc_req | input | 1 | Exception or interrupt request |
| exc_vec | input | 6 | Vector number |
| mem_wait | input | 1 | Memory wait; holds the execute stage |
| base_wr_en | input | 1 | Table base register write enable |
| base_wr_data | input | 24 | Table base write value |
| base_rd_data | output | 24 | Table base register value |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_pc | output | 24 | Address of the instruction in execute |
| ex_instr | output | 16 | Instruction in execute |

## Verification
Three kinds of event can fall in the same cycle. An exception can coincide with a taken branch. A branch or exception can arrive while a vector read is still outstanding. A redirect request can be raised while the memory wait is held. The bench provokes each case by driving the inputs together on one falling edge. In the busy-vector case it also keeps the modelled vector memory from answering for several cycles. The result is judged from the ports alone. The exception path must win, which shows in the `vec_rd_addr` that is issued and in the `ex_pc` that follows. The stall must freeze the execute outputs until the wait drops.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,  CC_ZSET  = 4'd1,  CC_ZCLR  = 4'd2,  CC_CSET  = 4'd3,
    CC_CCLR   = 4'd4,  CC_NSET  = 4'd5,  CC_NCLR  = 4'd6,  CC_VSET  = 4'd7,
    CC_VCLR   = 4'd8,  CC_SGT   = 4'd9,  CC_SGE   = 4'd10, CC_SLT   = 4'd11,
    CC_SLE    = 4'd12, CC_UGT   = 4'd13, CC_ULE   = 4'd14, CC_NEVER = 4'd15
  } cond_e;

  typedef enum logic {
    ST_VECTOR,
    ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    EX_HOLD,
    EX_LOAD,
    EX_FLUSH
  } ex_cmd_e;
endpackage

// File: rtl/fpc_cond_eval.sv
module fpc_cond_eval
  import fpc_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       take
);
  logic f_n, f_z, f_v, f_c;
  assign f_n = flags[3];
  assign f_z = flags[2];
  assign f_v = flags[1];
  assign f_c = flags[0];

  always_comb begin
    unique case (cond_e'(cond))
      CC_ALWAYS: take = 1'b1;
      CC_ZSET:   take = f_z;
      CC_ZCLR:   take = !f_z;
      CC_CSET:   take = f_c;
      CC_CCLR:   take = !f_c;
      CC_NSET:   take = f_n;
      CC_NCLR:   take = !f_n;
      CC_VSET:   take = f_v;
      CC_VCLR:   take = !f_v;
      CC_SGT:    take = !f_z && (f_n == f_v);
      CC_SGE:    take = (f_n == f_v);
      CC_SLT:    take = (f_n != f_v);
      CC_SLE:    take = f_z || (f_n != f_v);
      CC_UGT:    take = !f_c && !f_z;
      CC_ULE:    take = f_c || f_z;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpc_base_reg.sv
module fpc_base_reg #(
  parameter int               ADDR_W     = 24,
  parameter int               ALIGN_BITS = 10,
  parameter logic [ADDR_W-1:0] RESET_VAL = 24'hC00000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     base <= RESET_VAL & ~LOW_MASK;
    else if (wr_en) base <= wr_data & ~LOW_MASK;
  end

  assert_base_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (base & LOW_MASK) == '0);

  assert_base_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base[ADDR_W-1:ALIGN_BITS] == $past(wr_data[ADDR_W-1:ALIGN_BITS])));
endmodule

// File: rtl/fpc_exec_stage.sv
module fpc_exec_stage
  import fpc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ex_cmd_e            cmd,
  input  logic [ADDR_W-1:0]  pc_in,
  input  logic [INSTR_W-1:0] instr_in,
  output logic               e_valid,
  output logic [ADDR_W-1:0]  e_pc,
  output logic [INSTR_W-1:0] e_instr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_pc    <= '0;
      e_instr <= '0;
    end else begin
      unique case (cmd)
        EX_LOAD: begin
          e_valid <= 1'b1;
          e_pc    <= pc_in;
          e_instr <= instr_in;
        end
        EX_FLUSH: e_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  assert_flush_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == EX_FLUSH) |=> !e_valid);

  assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == EX_LOAD) |=> (e_valid && e_pc == $past(pc_in)));
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import fpc_pkg::*;
#(
  parameter int                ADDR_W     = 24,
  parameter int                INSTR_W    = 16,
  parameter int                VEC_NUM_W  = 6,
  parameter int                ALIGN_BITS = 10,
  parameter logic [ADDR_W-1:0] RESET_BASE = 24'hC00000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 imem_req,
  output logic [ADDR_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0]   imem_rdata,
  output logic                 vec_rd_req,
  output logic [ADDR_W-1:0]    vec_rd_addr,
  input  logic                 vec_rd_valid,
  input  logic [ADDR_W-1:0]    vec_rd_data,
  input  logic                 br_req,
  input  logic [3:0]           br_cond,
  input  logic [3:0]           br_flags,
  input  logic [ADDR_W-1:0]    br_target,
  input  logic                 exc_req,
  input  logic [VEC_NUM_W-1:0] exc_vec,
  input  logic                 mem_wait,
  input  logic                 base_wr_en,
  input  logic [ADDR_W-1:0]    base_wr_data,
  output logic [ADDR_W-1:0]    base_rd_data,
  output logic                 ex_valid,
  output logic [ADDR_W-1:0]    ex_pc,
  output logic [INSTR_W-1:0]   ex_instr
);
  localparam int                INSTR_BYTES = INSTR_W / 8;
  localparam logic [ADDR_W-1:0] PC_STEP     = ADDR_W'(INSTR_BYTES);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] vec_addr_q;
  logic [ADDR_W-1:0] table_base;
  logic [ADDR_W-1:0] entry_addr;
  logic              cond_ok;
  logic              accept, exc_go, br_go;
  ex_cmd_e           ex_cmd;

  fpc_cond_eval u_cond (
    .cond  (br_cond),
    .flags (br_flags),
    .take  (cond_ok)
  );

  fpc_base_reg #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .RESET_VAL  (RESET_BASE)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base    (table_base)
  );

  assign entry_addr = table_base + ADDR_W'({exc_vec, 2'b00});
  assign accept     = (state == ST_RUN) && !mem_wait;
  assign exc_go     = accept && exc_req;
  assign br_go      = accept && !exc_req && br_req && cond_ok;

  always_comb begin
    if (mem_wait)                            ex_cmd = EX_HOLD;
    else if (state == ST_VECTOR)             ex_cmd = EX_FLUSH;
    else if (exc_req || (br_req && cond_ok)) ex_cmd = EX_FLUSH;
    else                                     ex_cmd = EX_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_VECTOR;
      pc         <= RESET_BASE;
      vec_addr_q <= RESET_BASE;
    end else begin
      unique case (state)
        ST_VECTOR: begin
          if (vec_rd_valid) begin
            pc    <= vec_rd_data;
            state <= ST_RUN;
          end
        end
        default: begin
          if (exc_go) begin
            vec_addr_q <= entry_addr;
            state      <= ST_VECTOR;
          end else if (br_go) begin
            pc <= br_target;
          end else if (accept) begin
            pc <= pc + PC_STEP;
          end
        end
      endcase
    end
  end

  fpc_exec_stage #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
  ) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (ex_cmd),
    .pc_in    (pc),
    .instr_in (imem_rdata),
    .e_valid  (ex_valid),
    .e_pc     (ex_pc),
    .e_instr  (ex_instr)
  );

  assign imem_req     = (state == ST_RUN);
  assign imem_addr    = pc;
  assign vec_rd_req   = (state == ST_VECTOR);
  assign vec_rd_addr  = vec_addr_q;
  assign base_rd_data = table_base;

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !exc_req && !(br_req && cond_ok)) |=> (pc == $past(pc) + PC_STEP));

  assert_branch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_go |=> (pc == $past(br_target)));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait |=> ($stable(ex_valid) && $stable(ex_pc) && $stable(ex_instr)));

  assert_wait_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wait && state == ST_RUN) |=> $stable(imem_addr));

  assert_vector_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_req && vec_rd_valid) |=> (imem_req && imem_addr == $past(vec_rd_data)));

  assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go && br_req) |=> (vec_rd_req && vec_rd_addr == $past(entry_addr)));

  assert_vec_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_req && !vec_rd_valid) |=> (vec_rd_req && $stable(vec_rd_addr)));

  assert_redirect_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go || br_go) |=> !ex_valid);
endmodule

// File: tb/fetch_pc_seq_tb.sv
`timescale 1ns/1ps
module fetch_pc_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_req;
  logic [23:0] imem_addr;
  logic [15:0] imem_rdata;
  logic        vec_rd_req;
  logic [23:0] vec_rd_addr;
  logic        vec_rd_valid;
  logic [23:0] vec_rd_data;
  logic        br_req;
  logic [3:0]  br_cond;
  logic [3:0]  br_flags;
  logic [23:0] br_target;
  logic        exc_req;
  logic [5:0]  exc_vec;
  logic        mem_wait;
  logic        base_wr_en;
  logic [23:0] base_wr_data;
  logic [23:0] base_rd_data;
  logic        ex_valid;
  logic [23:0] ex_pc;
  logic [15:0] ex_instr;
  logic        vec_hold;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  function automatic logic [23:0] handler_of(input logic [23:0] a);
    return a ^ 24'h010000;
  endfunction

  function automatic logic [15:0] word_of(input logic [23:0] a);
    return a[15:0] ^ 16'hA5A5;
  endfunction

  assign imem_rdata   = word_of(imem_addr);
  assign vec_rd_valid = vec_rd_req && !vec_hold;
  assign vec_rd_data  = handler_of(vec_rd_addr);

  fetch_pc_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
    .vec_rd_valid(vec_rd_valid), .vec_rd_data(vec_rd_data),
    .br_req(br_req), .br_cond(br_cond), .br_flags(br_flags), .br_target(br_target),
    .exc_req(exc_req), .exc_vec(exc_vec), .mem_wait(mem_wait),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .base_rd_data(base_rd_data),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    chk("R2", "base after reset", 32'(base_rd_data), 32'h00C00000);
    chk("R1", "no issue in reset", 32'(ex_valid), 32'h0);
    rst_n = 1'b1;
    chk("R1", "reset vector req", 32'(vec_rd_req), 32'h1);
    chk("R1", "reset vector addr", 32'(vec_rd_addr), 32'h00C00000);
    cyc();
    chk("R1", "start fetch addr", 32'(imem_addr), 32'(handler_of(24'hC00000)));
    chk("R1", "nothing issued yet", 32'(ex_valid), 32'h0);
    cyc();
    chk("R3", "first ex_pc", 32'(ex_pc), 32'(handler_of(24'hC00000)));
    chk("R3", "first ex_instr", 32'(ex_instr), 32'(word_of(handler_of(24'hC00000))));
  endtask

  task automatic t_seq(input int n);
    for (int i = 0; i < n; i++) begin
      logic [23:0] p;
      p = ex_pc;
      cyc();
      chk("R3", "seq valid", 32'(ex_valid), 32'h1);
      chk("R3", "seq pc", 32'(ex_pc), 32'(p + 24'd2));
      chk("R3", "seq instr", 32'(ex_instr), 32'(word_of(p + 24'd2)));
    end
  endtask

  task automatic t_branch(input logic [3:0] cond, input logic [3:0] flags,
                          input bit taken, input logic [23:0] tgt);
    logic [23:0] p;
    p = ex_pc;
    br_req = 1'b1; br_cond = cond; br_flags = flags; br_target = tgt;
    cyc();
    br_req = 1'b0;
    if (taken) begin
      chk("R9", "bubble after branch", 32'(ex_valid), 32'h0);
      chk("R4", "fetch at target", 32'(imem_addr), 32'(tgt));
      cyc();
      chk("R4", "ex_pc at target", 32'(ex_pc), 32'(tgt));
      chk("R4", "ex_instr at target", 32'(ex_instr), 32'(word_of(tgt)));
    end else begin
      chk("R5", "untaken keeps valid", 32'(ex_valid), 32'h1);
      chk("R5", "untaken sequential", 32'(ex_pc), 32'(p + 24'd2));
    end
  endtask

  task automatic t_base_write(input logic [23:0] wval, input logic [23:0] expv);
    base_wr_en = 1'b1; base_wr_data = wval;
    cyc();
    base_wr_en = 1'b0;
    chk("R6", "base low bits zero", 32'(base_rd_data), 32'(expv));
  endtask

  task automatic t_exception(input logic [5:0] vnum, input logic [23:0] base);
    logic [23:0] ea;
    ea = base + 24'(vnum) * 24'd4;
    exc_req = 1'b1; exc_vec = vnum;
    cyc();
    exc_req = 1'b0;
    chk("R7", "vector req", 32'(vec_rd_req), 32'h1);
    chk("R7", "vector entry addr", 32'(vec_rd_addr), 32'(ea));
    chk("R9", "bubble after exception", 32'(ex_valid), 32'h0);
    cyc();
    chk("R7", "fetch at handler", 32'(imem_addr), 32'(handler_of(ea)));
    cyc();
    chk("R7", "ex_pc at handler", 32'(ex_pc), 32'(handler_of(ea)));
  endtask

  task automatic t_wait();
    logic [23:0] p;
    logic [15:0] w;
    p = ex_pc; w = ex_instr;
    mem_wait = 1'b1;
    br_req = 1'b1; br_cond = 4'd0; br_flags = 4'd0; br_target = 24'h008000;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R8", "wait holds ex_pc", 32'(ex_pc), 32'(p));
      chk("R8", "wait holds ex_instr", 32'(ex_instr), 32'(w));
      chk("R8", "wait holds fetch", 32'(imem_addr), 32'(p + 24'd2));
    end
    mem_wait = 1'b0; br_req = 1'b0;
    cyc();
    chk("R8", "resume sequential", 32'(ex_pc), 32'(p + 24'd2));
  endtask

  task automatic t_collide(input logic [5:0] vnum, input logic [23:0] base);
    logic [23:0] ea;
    ea = base + 24'(vnum) * 24'd4;
    exc_req = 1'b1; exc_vec = vnum;
    br_req = 1'b1; br_cond = 4'd0; br_flags = 4'd0; br_target = 24'h009000;
    cyc();
    exc_req = 1'b0; br_req = 1'b0;
    chk("R10", "exception beats branch req", 32'(vec_rd_req), 32'h1);
    chk("R10", "exception beats branch addr", 32'(vec_rd_addr), 32'(ea));
    cyc(); cyc();
    chk("R10", "handler after collision", 32'(ex_pc), 32'(handler_of(ea)));
  endtask

  task automatic t_vec_busy(input logic [5:0] vnum, input logic [23:0] base);
    logic [23:0] ea;
    ea = base + 24'(vnum) * 24'd4;
    vec_hold = 1'b1;
    exc_req = 1'b1; exc_vec = vnum;
    cyc();
    br_req = 1'b1; br_cond = 4'd0; br_flags = 4'd0; br_target = 24'h00A000;
    exc_vec = 6'd7;
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk("R10", "busy vector addr kept", 32'(vec_rd_addr), 32'(ea));
      chk("R10", "busy no issue", 32'(ex_valid), 32'h0);
    end
    vec_hold = 1'b0; br_req = 1'b0; exc_req = 1'b0;
    cyc(); cyc();
    chk("R10", "handler after busy vector", 32'(ex_pc), 32'(handler_of(ea)));
  endtask

  initial begin
    rst_n = 1'b0; br_req = 1'b0; br_cond = '0; br_flags = '0; br_target = '0;
    exc_req = 1'b0; exc_vec = '0; mem_wait = 1'b0; base_wr_en = 1'b0;
    base_wr_data = '0; vec_hold = 1'b0;
    cyc();
    t_reset();
    t_seq(4);
    t_branch(4'd1,  4'b0100, 1'b1, 24'h004000);
    t_seq(2);
    t_branch(4'd1,  4'b0000, 1'b0, 24'h004800);
    t_branch(4'd9,  4'b1010, 1'b1, 24'h004100);
    t_branch(4'd11, 4'b1010, 1'b0, 24'h004900);
    t_branch(4'd14, 4'b0001, 1'b1, 24'h004200);
    t_branch(4'd15, 4'b1111, 1'b0, 24'h004A00);
    t_branch(4'd0,  4'b0000, 1'b1, 24'h004300);
    t_exception(6'd5, 24'hC00000);
    t_seq(2);
    t_base_write(24'h123456, 24'h123400);
    t_exception(6'd3, 24'h123400);
    t_wait();
    t_collide(6'd2, 24'h123400);
    t_vec_busy(6'd1, 24'h123400);
    t_seq(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule